// File: doc/BRIEF.md
# Privilege-Gated Cycle and Retire Counter Registers

This block holds the hart's one 64-bit event count, which answers to both the cycle and the retired-instruction register names. It answers through a single-cycle CSR port. Software reads the count through machine-level names and through read-only user-level aliases. A per-privilege enable mask decides whether each user-level alias may be read. In machine mode every alias is open. In user mode the user mask applies, and in supervisor mode the supervisor mask applies.

When XLEN is 32 the count is split into a low word and a high word. Each word can be read, and each word can be written on its own. The hardware performance counters 3 to 31, their high words and their event selectors hold no state and read as zero. When a read is refused, the block reports it on a flag and returns zero. The pipeline decides what exception, if any, to raise.

Top module: `ctr_csr_unit`

## Requirements
- R1: After a synchronous reset, the count, the user enable mask (address 0x320) and the supervisor enable mask (address 0x321) are all zero.
- R2: The count rises by exactly one at each clock edge where `retire` is high and no count write happens. Otherwise it holds.
- R3: Four addresses return count bits XLEN-1:0: user cycle 0xC00, user instret 0xC02, machine cycle 0xB00 and machine instret 0xB02. When XLEN is 32, the addresses 0xC80, 0xC82, 0xB80 and 0xB82 return count bits 63:32.
- R4: When XLEN is 32, a write to 0xB00 or 0xB02 replaces only count bits 31:0. A write to 0xB80 or 0xB82 replaces only bits 63:32. When XLEN is 64, a write to 0xB00 or 0xB02 replaces the whole count.
- R5: When a count write and a `retire` pulse fall in the same cycle, the written value is stored and the increment is lost.
- R6: The effective mask depends on `priv`. It is the user mask for `priv`=0 and the supervisor mask for `priv`=1. For 3 (machine) and for 2 it is all ones. A user alias at 0xC00-0xC1F or 0xC80-0xC9F is allowed when bit (address mod 32) of that mask is set.
- R7: A read (`csr_rd_en`=1) of a user alias that is not allowed raises `csr_denied` and returns zero. `csr_denied` is never high without a read of a user alias.
- R8: The following read zero, and writes to them change nothing: performance counters 0xB03-0xB1F and 0xB83-0xB9F, user aliases 0xC03-0xC1F and 0xC83-0xC9F when allowed, and event selectors 0x323-0x33F.
- R9: Both enable masks keep all XLEN bits of the written value.
- R10: The user aliases are read-only. A write to them leaves the count unchanged.
- R11: `csr_hit` is high exactly when the address belongs to this block. Addresses 0xC01, 0xB01 and 0x322 do not belong to it, and neither do the high-word addresses when XLEN is 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| retire | input | 1 | One pulse per retired instruction |
| csr_addr | input | 12 | CSR address |
| csr_rd_en | input | 1 | Read strobe; qualifies `csr_denied` |
| csr_wr_en | input | 1 | Write strobe, takes effect at the clock edge |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data for `csr_addr` |
| csr_hit | output | 1 | Address is owned by this block |
| csr_denied | output | 1 | Read of a user alias refused by the effective mask |

## Verification
The count is driven by runs of retire pulses of several lengths, and every name is read afterwards. This shows that all names share one count and that the increment step is exactly one. A low-word value just below the 32-bit wrap, followed by further pulses, shows that the carry reaches the high word. Separate low and high writes show that each write leaves the other word alone, and a write in the same cycle as a retire pulse shows which of the two wins. The user aliases are read under all three privileges, with mask patterns that open one alias and keep its neighbour closed. This separates the user mask from the supervisor mask and machine mode from both.

// File: rtl/ctr_csr_pkg.sv
package ctr_csr_pkg;

    localparam int CNT_W = 64;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic [3:0] {
        CK_NONE,
        CK_UALIAS_LO,
        CK_UALIAS_HI,
        CK_UHPM,
        CK_MCNT_LO,
        CK_MCNT_HI,
        CK_MHPM,
        CK_EVENT,
        CK_UMASK,
        CK_SMASK
    } csr_kind_e;

    typedef struct packed {
        csr_kind_e  kind;
        logic [4:0] slot;
        logic       user_alias;
    } csr_class_t;

    localparam logic [11:0] BASE_USER_LO = 12'hC00;
    localparam logic [11:0] BASE_USER_HI = 12'hC80;
    localparam logic [11:0] BASE_MACH_LO = 12'hB00;
    localparam logic [11:0] BASE_MACH_HI = 12'hB80;
    localparam logic [11:0] BASE_SETUP   = 12'h320;

    localparam logic [4:0] SLOT_CYCLE   = 5'd0;
    localparam logic [4:0] SLOT_INSTRET = 5'd2;
    localparam logic [4:0] SLOT_HPM_LO  = 5'd3;
    localparam logic [4:0] SLOT_UMASK   = 5'd0;
    localparam logic [4:0] SLOT_SMASK   = 5'd1;

    function automatic logic is_count_slot(input logic [4:0] s);
        return (s == SLOT_CYCLE) || (s == SLOT_INSTRET);
    endfunction

    function automatic csr_class_t classify(input logic [11:0] a, input logic split);
        csr_class_t c;
        logic [11:0] base;
        logic [4:0]  s;
        base = {a[11:5], 5'b0};
        s    = a[4:0];
        c.kind = CK_NONE;
        c.slot = s;
        case (base)
            BASE_USER_LO: begin
                if (is_count_slot(s))       c.kind = CK_UALIAS_LO;
                else if (s >= SLOT_HPM_LO)  c.kind = CK_UHPM;
            end
            BASE_USER_HI: begin
                if (split && is_count_slot(s))      c.kind = CK_UALIAS_HI;
                else if (split && s >= SLOT_HPM_LO) c.kind = CK_UHPM;
            end
            BASE_MACH_LO: begin
                if (is_count_slot(s))       c.kind = CK_MCNT_LO;
                else if (s >= SLOT_HPM_LO)  c.kind = CK_MHPM;
            end
            BASE_MACH_HI: begin
                if (split && is_count_slot(s))      c.kind = CK_MCNT_HI;
                else if (split && s >= SLOT_HPM_LO) c.kind = CK_MHPM;
            end
            BASE_SETUP: begin
                if (s == SLOT_UMASK)        c.kind = CK_UMASK;
                else if (s == SLOT_SMASK)   c.kind = CK_SMASK;
                else if (s >= SLOT_HPM_LO)  c.kind = CK_EVENT;
            end
            default: c.kind = CK_NONE;
        endcase
        c.user_alias = (c.kind == CK_UALIAS_LO) || (c.kind == CK_UALIAS_HI) ||
                       (c.kind == CK_UHPM);
        return c;
    endfunction

endpackage

// File: rtl/ctr_csr_decode.sv
module ctr_csr_decode
    import ctr_csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [11:0] addr,
    output csr_class_t  cls
);
    // High-word names exist only when the count is wider than one register.
    localparam logic SPLIT = (XLEN < CNT_W);

    always_comb begin
        cls = classify(addr, SPLIT);
    end
endmodule

// File: rtl/ctr_csr_gate.sv
module ctr_csr_gate
    import ctr_csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      priv,
    input  logic [XLEN-1:0] umask,
    input  logic [XLEN-1:0] smask,
    input  logic [4:0]      slot,
    output logic            allowed
);
    logic [XLEN-1:0] eff_mask;
    priv_e           level;

    always_comb begin
        level = priv_e'(priv);
        case (level)
            PRIV_U:  eff_mask = umask;
            PRIV_S:  eff_mask = smask;
            default: eff_mask = '1;
        endcase
        allowed = eff_mask[slot];
    end
endmodule

// File: rtl/ctr_csr_masks.sv
module ctr_csr_masks #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_user,
    input  logic            wr_super,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] umask,
    output logic [XLEN-1:0] smask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            umask <= '0;
            smask <= '0;
        end else begin
            if (wr_user)  umask <= wdata;
            if (wr_super) smask <= wdata;
        end
    end
endmodule

// File: rtl/ctr_csr_count.sv
module ctr_csr_count
    import ctr_csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             retire,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [XLEN-1:0]  wdata,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] lo_written;
    logic [CNT_W-1:0] hi_written;

    generate
        if (XLEN < CNT_W) begin : g_split
            assign lo_written = {count[CNT_W-1:XLEN], wdata};
            assign hi_written = {wdata[CNT_W-XLEN-1:0], count[XLEN-1:0]};
        end else begin : g_full
            assign lo_written = wdata[CNT_W-1:0];
            assign hi_written = count;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (wr_lo) begin
            count <= lo_written;
        end else if (wr_hi) begin
            count <= hi_written;
        end else if (retire) begin
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ctr_csr_unit.sv
module ctr_csr_unit
    import ctr_csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      priv,
    input  logic            retire,
    input  logic [11:0]     csr_addr,
    input  logic            csr_rd_en,
    input  logic            csr_wr_en,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_hit,
    output logic            csr_denied
);
    csr_class_t       cls;
    logic             allowed;
    logic [XLEN-1:0]  umask;
    logic [XLEN-1:0]  smask;
    logic [CNT_W-1:0] count_q;
    logic [XLEN-1:0]  cnt_lo;
    logic [XLEN-1:0]  cnt_hi;
    logic             wr_lo;
    logic             wr_hi;
    logic             wr_user;
    logic             wr_super;
    logic             cnt_write;

    ctr_csr_decode #(.XLEN(XLEN)) u_decode (
        .addr (csr_addr),
        .cls  (cls)
    );

    ctr_csr_gate #(.XLEN(XLEN)) u_gate (
        .priv    (priv),
        .umask   (umask),
        .smask   (smask),
        .slot    (cls.slot),
        .allowed (allowed)
    );

    assign wr_lo     = csr_wr_en && (cls.kind == CK_MCNT_LO);
    assign wr_hi     = csr_wr_en && (cls.kind == CK_MCNT_HI);
    assign wr_user   = csr_wr_en && (cls.kind == CK_UMASK);
    assign wr_super  = csr_wr_en && (cls.kind == CK_SMASK);
    assign cnt_write = wr_lo || wr_hi;

    ctr_csr_masks #(.XLEN(XLEN)) u_masks (
        .clk      (clk),
        .rst      (rst),
        .wr_user  (wr_user),
        .wr_super (wr_super),
        .wdata    (csr_wdata),
        .umask    (umask),
        .smask    (smask)
    );

    ctr_csr_count #(.XLEN(XLEN)) u_count (
        .clk    (clk),
        .rst    (rst),
        .retire (retire),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .wdata  (csr_wdata),
        .count  (count_q)
    );

    assign cnt_lo = count_q[XLEN-1:0];

    generate
        if (XLEN < CNT_W) begin : g_hi_word
            assign cnt_hi = count_q[CNT_W-1 -: XLEN];
        end else begin : g_no_hi_word
            assign cnt_hi = '0;
        end
    endgenerate

    always_comb begin
        csr_rdata  = '0;
        csr_hit    = (cls.kind != CK_NONE);
        csr_denied = csr_rd_en && cls.user_alias && !allowed;
        case (cls.kind)
            CK_UALIAS_LO: if (allowed) csr_rdata = cnt_lo;
            CK_UALIAS_HI: if (allowed) csr_rdata = cnt_hi;
            CK_MCNT_LO:   csr_rdata = cnt_lo;
            CK_MCNT_HI:   csr_rdata = cnt_hi;
            CK_UMASK:     csr_rdata = umask;
            CK_SMASK:     csr_rdata = smask;
            default:      csr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ctr_csr_unit_chk.sv
module ctr_csr_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      priv,
    input logic            retire,
    input logic            cnt_write,
    input logic [63:0]     count,
    input logic            csr_rd_en,
    input logic            csr_hit,
    input logic            csr_denied,
    input logic [XLEN-1:0] csr_rdata
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count == 64'd0));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(retire) && !$past(cnt_write)) |-> (count == $past(count) + 64'd1));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(retire) && !$past(cnt_write)) |-> $stable(count));

    assert_denied_zero_R7: assert property (@(posedge clk) disable iff (rst)
        csr_denied |-> (csr_rdata == '0));

    assert_denied_needs_read_R7: assert property (@(posedge clk) disable iff (rst)
        csr_denied |-> (csr_rd_en && csr_hit));

    assert_machine_open_R6: assert property (@(posedge clk) disable iff (rst)
        (priv == 2'd3) |-> !csr_denied);
endmodule

bind ctr_csr_unit ctr_csr_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .priv       (priv),
    .retire     (retire),
    .cnt_write  (cnt_write),
    .count      (count_q),
    .csr_rd_en  (csr_rd_en),
    .csr_hit    (csr_hit),
    .csr_denied (csr_denied),
    .csr_rdata  (csr_rdata)
);

// File: tb/test_ctr_csr_unit.sv
module test_ctr_csr_unit;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      priv = 2'd3;
    logic            retire = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic            csr_rd_en = 1'b0;
    logic            csr_wr_en = 1'b0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            csr_hit;
    logic            csr_denied;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 0;
    logic [63:0] m_cnt = 64'd0;

    ctr_csr_unit #(.XLEN(XLEN)) i_ctr_csr_unit (
        .clk(clk), .rst(rst), .priv(priv), .retire(retire),
        .csr_addr(csr_addr), .csr_rd_en(csr_rd_en), .csr_wr_en(csr_wr_en),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_hit(csr_hit),
        .csr_denied(csr_denied)
    );

    always #2ns clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d,
                      output logic den, output logic hit);
        @(negedge clk);
        csr_addr  = a;
        csr_rd_en = 1'b1;
        #1ns;
        d   = csr_rdata;
        den = csr_denied;
        hit = csr_hit;
        csr_rd_en = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_addr  = a;
        csr_wdata = d;
        csr_wr_en = 1'b1;
        @(negedge clk);
        csr_wr_en = 1'b0;
    endtask

    task automatic pulses(input int n);
        @(negedge clk);
        retire = 1'b1;
        repeat (n) @(negedge clk);
        retire = 1'b0;
        m_cnt = m_cnt + 64'(n);
    endtask

    task automatic t_reset;
        logic [31:0] d; logic den, h;
        rd(12'hB00, d, den, h); chk("R1 count low after reset", d, 32'h0);
        rd(12'hB80, d, den, h); chk("R1 count high after reset", d, 32'h0);
        rd(12'h320, d, den, h); chk("R1 user mask after reset", d, 32'h0);
        rd(12'h321, d, den, h); chk("R1 supervisor mask after reset", d, 32'h0);
    endtask

    task automatic t_retire_alias;
        logic [31:0] d; logic den, h;
        pulses(5);
        rd(12'hB00, d, den, h); chk("R2 five pulses mcycle", d, m_cnt[31:0]);
        rd(12'hB02, d, den, h); chk("R3 minstret same count", d, m_cnt[31:0]);
        rd(12'hC00, d, den, h); chk("R3 user cycle alias", d, m_cnt[31:0]);
        rd(12'hC02, d, den, h); chk("R3 user instret alias", d, m_cnt[31:0]);
        pulses(1);
        rd(12'hB02, d, den, h); chk("R2 single pulse", d, m_cnt[31:0]);
    endtask

    task automatic t_split_write;
        logic [31:0] d; logic den, h;
        wr(12'hB00, 32'hFFFF_FFFE);
        m_cnt = {m_cnt[63:32], 32'hFFFF_FFFE};
        pulses(3);
        rd(12'hB00, d, den, h); chk("R2 low word after wrap", d, 32'h1);
        rd(12'hB80, d, den, h); chk("R3 carry into high word", d, 32'h1);
        rd(12'hC82, d, den, h); chk("R3 user instret high alias", d, 32'h1);
        wr(12'hB82, 32'h0000_ABCD);
        m_cnt = {32'h0000_ABCD, m_cnt[31:0]};
        rd(12'hB80, d, den, h); chk("R4 high write stored", d, 32'h0000_ABCD);
        rd(12'hB00, d, den, h); chk("R4 high write keeps low", d, 32'h1);
        wr(12'hB02, 32'h0000_0777);
        rd(12'hB80, d, den, h); chk("R4 low write keeps high", d, 32'h0000_ABCD);
        rd(12'hB00, d, den, h); chk("R4 low write stored", d, 32'h0000_0777);
        m_cnt = {m_cnt[63:32], 32'h0000_0777};
    endtask

    task automatic t_priority;
        logic [31:0] d; logic den, h;
        @(negedge clk);
        csr_addr = 12'hB00; csr_wdata = 32'h100; csr_wr_en = 1'b1; retire = 1'b1;
        @(negedge clk);
        csr_wr_en = 1'b0; retire = 1'b0;
        m_cnt = {m_cnt[63:32], 32'h100};
        rd(12'hB00, d, den, h); chk("R5 write beats retire", d, 32'h100);
        rd(12'hB80, d, den, h); chk("R5 high word untouched", d, m_cnt[63:32]);
    endtask

    task automatic t_gating;
        logic [31:0] d; logic den, h;
        priv = 2'd0;
        rd(12'hC00, d, den, h);
        chk("R7 user cycle denied flag", {31'b0, den}, 32'h1);
        chk("R7 user cycle denied data", d, 32'h0);
        wr(12'h320, 32'h1);
        rd(12'hC00, d, den, h);
        chk("R6 user mask bit0 opens cycle", d, m_cnt[31:0]);
        chk("R6 user cycle not denied", {31'b0, den}, 32'h0);
        rd(12'hC02, d, den, h);
        chk("R6 user mask bit2 clear denies instret", {31'b0, den}, 32'h1);
        priv = 2'd1;
        rd(12'hC00, d, den, h);
        chk("R6 supervisor ignores user mask", {31'b0, den}, 32'h1);
        wr(12'h321, 32'h4);
        rd(12'hC02, d, den, h);
        chk("R6 supervisor mask bit2 opens instret", d, m_cnt[31:0]);
        rd(12'hC00, d, den, h);
        chk("R6 supervisor mask bit0 clear", {31'b0, den}, 32'h1);
        priv = 2'd3;
        rd(12'hC02, d, den, h);
        chk("R6 machine mode open", {31'b0, den}, 32'h0);
        @(negedge clk);
        csr_addr = 12'hC00; csr_rd_en = 1'b0; priv = 2'd0;
        wr(12'h320, 32'h0);
        @(negedge clk);
        csr_addr = 12'hC00;
        #1ns;
        chk("R7 no denied without read", {31'b0, csr_denied}, 32'h0);
        priv = 2'd3;
    endtask

    task automatic t_hpm;
        logic [31:0] d; logic den, h;
        rd(12'hB05, d, den, h); chk("R8 machine hpm reads zero", d, 32'h0);
        chk("R11 machine hpm hit", {31'b0, h}, 32'h1);
        rd(12'hB9F, d, den, h); chk("R8 machine hpm high reads zero", d, 32'h0);
        rd(12'hC07, d, den, h); chk("R8 user hpm allowed zero", d, 32'h0);
        wr(12'h325, 32'h5);
        rd(12'h325, d, den, h); chk("R8 event selector reads zero", d, 32'h0);
        wr(12'hB05, 32'h1234);
        rd(12'hB05, d, den, h); chk("R8 hpm write ignored", d, 32'h0);
        rd(12'hB00, d, den, h); chk("R8 hpm write leaves count", d, m_cnt[31:0]);
        priv = 2'd0;
        rd(12'hC87, d, den, h); chk("R7 user hpm high denied", {31'b0, den}, 32'h1);
        priv = 2'd3;
    endtask

    task automatic t_masks_alias_hit;
        logic [31:0] d; logic den, h;
        wr(12'h320, 32'hFFFF_FFFF);
        rd(12'h320, d, den, h); chk("R9 user mask full width", d, 32'hFFFF_FFFF);
        wr(12'h321, 32'h8000_0008);
        rd(12'h321, d, den, h); chk("R9 supervisor mask full width", d, 32'h8000_0008);
        wr(12'hC00, 32'h55);
        rd(12'hB00, d, den, h); chk("R10 user alias write ignored", d, m_cnt[31:0]);
        wr(12'hC80, 32'h66);
        rd(12'hB80, d, den, h); chk("R10 user high alias write ignored", d, m_cnt[63:32]);
        rd(12'hC01, d, den, h); chk("R11 0xC01 not owned", {31'b0, h}, 32'h0);
        rd(12'hB01, d, den, h); chk("R11 0xB01 not owned", {31'b0, h}, 32'h0);
        rd(12'h322, d, den, h); chk("R11 0x322 not owned", {31'b0, h}, 32'h0);
        rd(12'h323, d, den, h); chk("R11 event selector owned", {31'b0, h}, 32'h1);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_retire_alias();
        t_split_write();
        t_priority();
        t_gating();
        t_hpm();
        t_masks_alias_hit();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #400us;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end
endmodule